// File: doc/BRIEF.md
# Tuner Command Receiver over I2C

This block is a write-only I2C target that receives tuning commands for a frequency synthesizer. A transfer starts with a start condition and the device address with the write bit. Two or four data bytes follow, and a stop condition ends it. The data bytes come in pairs. The first byte of each pair says what kind of pair it is:

- A frequency pair carries a 15-bit divider ratio.
- A control pair carries a control byte and a byte whose low four bits drive the band-switch outputs.

The receiver samples the bus lines with the system clock. It acknowledges each accepted byte by pulling SDA low, and it holds each received pair until the stop condition. At the stop condition it copies every complete pair into its output registers in one step, so the tuner never sees half a command.

A host may send only a frequency pair or only a control pair, or both pairs in either order. An address for another device, a read request, a repeated pair type or a byte beyond the fourth makes the receiver stop acknowledging. In each of these cases it leaves its outputs as they were.

Top module: `tuner_cmd_rx`

## Requirements
- R1: The address byte is acknowledged only when it equals `{DEV_ADDR, 1'b0}`, which is 8'hC2 by default. While it acknowledges, `sda_oe` is 1 from the SCL fall after the eighth bit until the SCL fall after the ninth clock.
- R2: After an address byte that mismatches or has bit 0 (read) set, no byte is acknowledged until the next start condition, and the outputs do not change at the following stop.
- R3: A first-of-pair byte with bit 7 = 0 starts a frequency pair. At stop, `div_ratio` = {first[6:0], second[7:0]}. A first-of-pair byte with bit 7 = 1 starts a control pair. At stop, `ctrl_byte` = first and `band_out` = second[3:0].
- R4: Each data byte of the four legal orderings is acknowledged: control+band, freq-high+freq-low, control+band+freq pair, and freq pair+control+band. The outputs keep their old values until the stop condition.
- R5: The latch is per pair. A stop updates only the pairs received in that transfer, and the other output bank keeps its value.
- R6: A pair whose second byte has not arrived before the stop is discarded. A complete pair in the same transfer is still latched.
- R7: A repeated start discards all pairs of the transfer it interrupts. The new transfer is then received normally.
- R8: A data byte out of sequence is not acknowledged: either a fifth data byte, or a first-of-pair byte of a type already received in the transfer. The transfer is then dropped, and nothing from it is latched.
- R9: After reset, `sda_oe`, `div_ratio`, `ctrl_byte` and `band_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 = drive SDA low (acknowledge) |
| div_ratio | output | 15 | Latched divider ratio |
| ctrl_byte | output | 8 | Latched control byte |
| band_out | output | 4 | Latched band-switch outputs |

## Verification
A bit counter that slips, or a wrong sequencer state, shows up first on the acknowledge. Within the same byte the ninth-clock SDA level is wrong: a missing acknowledge on a legal byte, or one on a byte that should be refused. A pending-pair flag that is wrong shows only at the next stop condition, as an output bank that changes when it should hold or holds when it should change. The bench therefore checks the acknowledge of every byte and compares all three output banks after every stop. It also checks them just before each stop, to catch early updates.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_DATA = 2'd2
  } seq_st_t;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_q, sda_q;
  logic scl_cur, sda_cur;

  assign scl_cur = scl_ff[STAGES-1];
  assign sda_cur = sda_ff[STAGES-1];

  // idle bus is high on both lines: reset there so no false condition appears
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_cur;
      sda_q  <= sda_cur;
    end
  end

  assign sda_bit   = sda_cur;
  assign scl_rise  = ~scl_q & scl_cur;
  assign scl_fall  = scl_q & ~scl_cur;
  assign start_det = scl_q & scl_cur & sda_q & ~sda_cur;
  assign stop_det  = scl_q & scl_cur & ~sda_q & sda_cur;
endmodule

// File: rtl/tcr_byte_rx.sv
module tcr_byte_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_det,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_bit,
  input  logic         ack_ok,
  output logic [W-1:0] rx_byte,
  output logic         byte_done,
  output logic         sda_oe
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          in_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      in_ack    <= 1'b0;
      sda_oe    <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (start_det) begin
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_rise && !in_ack && cnt != CW'(W)) begin
        rx_byte <= {rx_byte[W-2:0], sda_bit};
        cnt     <= cnt + 1'b1;
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        cnt    <= '0;
      end else if (scl_fall && cnt == CW'(W)) begin
        in_ack    <= 1'b1;
        sda_oe    <= ack_ok;
        byte_done <= 1'b1;
      end
    end
  end

  // R1: the line is pulled only inside the acknowledge slot
  a_r1_oe_in_slot: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> in_ack);
  // R1: the pull-down ends at the SCL fall of the ninth clock
  a_r1_oe_release: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && scl_fall && !start_det) |=> !sda_oe);
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W));
endmodule

// File: rtl/tcr_seq.sv
module tcr_seq
  import tcr_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h61,
  parameter int          DIV_W    = 15,
  parameter int          BAND_W   = 4,
  parameter int          PAIRS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ack_ok,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic [BAND_W-1:0] band_out
);
  localparam int MAXB = 2 * PAIRS;
  localparam int DCW  = $clog2(MAXB + 1);
  localparam int HI_W = DIV_W - BYTE_W;

  seq_st_t           st;
  logic [DCW-1:0]    dcnt;
  logic [BYTE_W-1:0] hold;
  logic              seen_freq, seen_ctrl;
  logic              have_freq, have_ctrl;
  logic [DIV_W-1:0]  pend_div;
  logic [BYTE_W-1:0] pend_ctrl;
  logic [BAND_W-1:0] pend_band;

  always_comb begin
    ack_ok = 1'b0;
    case (st)
      SQ_ADDR: ack_ok = (rx_byte == {DEV_ADDR[ADDR_W-1:0], 1'b0});
      SQ_DATA: begin
        if (dcnt == DCW'(MAXB))  ack_ok = 1'b0;
        else if (dcnt[0])        ack_ok = 1'b1;
        else if (rx_byte[BYTE_W-1]) ack_ok = !seen_ctrl;
        else                     ack_ok = !seen_freq;
      end
      default: ack_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      dcnt      <= '0;
      hold      <= '0;
      seen_freq <= 1'b0;
      seen_ctrl <= 1'b0;
      have_freq <= 1'b0;
      have_ctrl <= 1'b0;
      pend_div  <= '0;
      pend_ctrl <= '0;
      pend_band <= '0;
      div_ratio <= '0;
      ctrl_byte <= '0;
      band_out  <= '0;
    end else if (start_det) begin
      st        <= SQ_ADDR;
      dcnt      <= '0;
      seen_freq <= 1'b0;
      seen_ctrl <= 1'b0;
      have_freq <= 1'b0;
      have_ctrl <= 1'b0;
    end else if (stop_det) begin
      if (st == SQ_DATA && have_freq) div_ratio <= pend_div;
      if (st == SQ_DATA && have_ctrl) begin
        ctrl_byte <= pend_ctrl;
        band_out  <= pend_band;
      end
      st        <= SQ_IDLE;
      have_freq <= 1'b0;
      have_ctrl <= 1'b0;
    end else if (byte_done && st != SQ_IDLE) begin
      if (!ack_ok) begin
        st        <= SQ_IDLE;
        have_freq <= 1'b0;
        have_ctrl <= 1'b0;
      end else if (st == SQ_ADDR) begin
        st   <= SQ_DATA;
        dcnt <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
        if (!dcnt[0]) begin
          hold <= rx_byte;
          if (rx_byte[BYTE_W-1]) seen_ctrl <= 1'b1;
          else                   seen_freq <= 1'b1;
        end else if (hold[BYTE_W-1]) begin
          pend_ctrl <= hold;
          pend_band <= rx_byte[BAND_W-1:0];
          have_ctrl <= 1'b1;
        end else begin
          pend_div  <= {hold[HI_W-1:0], rx_byte};
          have_freq <= 1'b1;
        end
      end
    end
  end

  // R4: outputs move only on the cycle after a stop condition
  a_r4_div_hold: assert property (@(posedge clk) disable iff (rst)
    !stop_det |=> $stable(div_ratio));
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !stop_det |=> ($stable(ctrl_byte) && $stable(band_out)));
  // R7: any start, repeated or not, drops pending pairs
  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!have_freq && !have_ctrl));
  a_r8_dcnt_bound: assert property (@(posedge clk) disable iff (rst)
    dcnt <= DCW'(MAXB));
endmodule

// File: rtl/tuner_cmd_rx.sv
module tuner_cmd_rx
  import tcr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h61,
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_W       = 15,
  parameter int         BAND_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic [BAND_W-1:0] band_out
);
  logic sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, ack_ok;
  logic [BYTE_W-1:0] rx_byte;

  tcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tcr_byte_rx #(.W(BYTE_W)) u_byte (
    .clk(clk), .rst(rst), .start_det(start_det), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_bit(sda_bit), .ack_ok(ack_ok),
    .rx_byte(rx_byte), .byte_done(byte_done), .sda_oe(sda_oe)
  );

  tcr_seq #(
    .ADDR_W(7), .DEV_ADDR(DEV_ADDR), .DIV_W(DIV_W), .BAND_W(BAND_W), .PAIRS(2)
  ) u_seq (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .rx_byte(rx_byte), .ack_ok(ack_ok),
    .div_ratio(div_ratio), .ctrl_byte(ctrl_byte), .band_out(band_out)
  );
endmodule

// File: tb/tuner_cmd_rx_test.sv
module tuner_cmd_rx_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [14:0] div_ratio;
  logic [7:0]  ctrl_byte;
  logic [3:0]  band_out;

  always #5 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  tuner_cmd_rx uut (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line),
    .sda_oe(sda_oe), .div_ratio(div_ratio), .ctrl_byte(ctrl_byte),
    .band_out(band_out)
  );

  typedef struct {
    logic [14:0] div;
    logic [7:0]  ctl;
    logic [3:0]  bnd;
    int          req;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  logic [14:0] cur_div = '0;
  logic [7:0]  cur_ctl = '0;
  logic [3:0]  cur_bnd = '0;
  logic [7:0]  pkt [7];
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked, output bit oe_early);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq();
      scl_drv = 1'b1; wq(); wq();
      scl_drv = 1'b0; wq();
    end
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    acked = !sda_line;
    wq();
    scl_drv = 1'b0; wq();
    oe_early = sda_oe;
  endtask

  // drives pkt[0..n-1]; the model follows R1..R8
  task automatic xfer(input int n, input bit do_stop, input int req);
    bit ok, sf, sc, hf, hc, ea, acked, oe_late;
    logic [7:0]  hold;
    logic [14:0] nd;
    logic [7:0]  nc;
    logic [3:0]  nb;
    string tg;
    ok = (pkt[0] == 8'hC2);
    sf = 0; sc = 0; hf = 0; hc = 0; hold = '0; nd = '0; nc = '0; nb = '0;
    bus_start();
    put_byte(pkt[0], acked, oe_late);
    chk(acked == ok, ok ? "R1" : "R2", "address ack", 32'(acked), 32'(ok));
    chk(!oe_late, "R1", "release after ninth clock", 32'(oe_late), 32'd0);
    for (int i = 1; i < n; i++) begin
      int di;
      di = i - 1;
      if (!ok)          ea = 0;
      else if (di >= 4) ea = 0;
      else if (di % 2)  ea = 1;
      else              ea = pkt[i][7] ? !sc : !sf;
      tg = !(pkt[0] == 8'hC2) ? "R2" : (ea ? "R4" : "R8");
      put_byte(pkt[i], acked, oe_late);
      chk(acked == ea, tg, "data ack", 32'(acked), 32'(ea));
      if (ok) begin
        if (!ea) begin
          ok = 0; hf = 0; hc = 0;
        end else if (di % 2 == 0) begin
          hold = pkt[i];
          if (pkt[i][7]) sc = 1; else sf = 1;
        end else if (hold[7]) begin
          hc = 1; nc = hold; nb = pkt[i][3:0];
        end else begin
          hf = 1; nd = {hold[6:0], pkt[i]};
        end
      end
    end
    // R4: nothing may be latched before the stop condition
    chk(div_ratio == cur_div && ctrl_byte == cur_ctl && band_out == cur_bnd,
        "R4", "outputs held before stop", {div_ratio, ctrl_byte, 9'd0}, {cur_div, cur_ctl, 9'd0});
    if (do_stop) begin
      bus_stop();
      if (ok && hf) cur_div = nd;
      if (ok && hc) begin cur_ctl = nc; cur_bnd = nb; end
      wq(); wq();
      exp_q.push_back('{div: cur_div, ctl: cur_ctl, bnd: cur_bnd, req: req});
      wait (exp_q.size() == 0);
    end
  endtask

  // monitor: compares latched outputs against the scoreboard
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      chk(div_ratio == e.div, $sformatf("R%0d", e.req), "div_ratio", 32'(div_ratio), 32'(e.div));
      chk(ctrl_byte == e.ctl, $sformatf("R%0d", e.req), "ctrl_byte", 32'(ctrl_byte), 32'(e.ctl));
      chk(band_out == e.bnd, $sformatf("R%0d", e.req), "band_out", 32'(band_out), 32'(e.bnd));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(sda_oe == 0, "R9", "sda_oe after reset", 32'(sda_oe), 32'd0);
    chk(div_ratio == 0 && ctrl_byte == 0 && band_out == 0, "R9", "outputs after reset",
        {div_ratio, ctrl_byte, 9'd0}, 32'd0);

    // R3 R4 control+band only
    pkt = '{8'hC2, 8'h8E, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00}; xfer(3, 1, 3);
    // R3 R5 frequency only, control bank must keep 8E/5
    pkt = '{8'hC2, 8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 8'h00}; xfer(3, 1, 5);
    // R4 control, band, freq
    pkt = '{8'hC2, 8'hA1, 8'h0A, 8'h3C, 8'h5A, 8'h00, 8'h00}; xfer(5, 1, 4);
    // R4 freq, control, band; maximum ratio
    pkt = '{8'hC2, 8'h7F, 8'hFF, 8'hFF, 8'hF3, 8'h00, 8'h00}; xfer(5, 1, 4);
    // R2 mismatching address
    pkt = '{8'hC4, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00}; xfer(3, 1, 2);
    // R2 read bit set
    pkt = '{8'hC3, 8'h81, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00}; xfer(3, 1, 2);
    // R6 freq pair complete, control pair incomplete
    pkt = '{8'hC2, 8'h05, 8'h55, 8'h90, 8'h00, 8'h00, 8'h00}; xfer(4, 1, 6);
    // R7 repeated start abandons a full freq pair, then control pair lands
    pkt = '{8'hC2, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00}; xfer(3, 0, 7);
    pkt = '{8'hC2, 8'hC6, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00}; xfer(3, 1, 7);
    // R8 fifth data byte
    pkt = '{8'hC2, 8'h80, 8'h01, 8'h01, 8'h01, 8'h99, 8'h00}; xfer(6, 1, 8);
    // R8 repeated pair type, later bytes ignored
    pkt = '{8'hC2, 8'h12, 8'h34, 8'h22, 8'h33, 8'h8E, 8'h05}; xfer(7, 1, 8);
    // R1 a normal transfer still works afterwards
    pkt = '{8'hC2, 8'h2A, 8'hB7, 8'hB0, 8'h06, 8'h00, 8'h00}; xfer(5, 1, 1);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule